// File: doc/BRIEF.md
# MDIO Management Master

This block lets software talk to an external Ethernet PHY over the two-wire management bus. It sits on a simple word-addressed register port and runs one Clause 22 transaction at a time. It builds the whole serial frame itself: preamble, start, opcode, PHY and register addresses, turnaround and sixteen data bits. It drives MDC from a programmable divisor and controls the tri-state enable of the bidirectional MDIO pin. On a read it captures the data the PHY returns.

Software first enables the bus and picks a divisor in one write to the configuration word. For a write it loads the data word. It then writes the control word with the PHY address, the register address, one opcode bit and the initiate bit. It polls the ready bit in the control word until it returns high, and then fetches the result from the read-data word. Scanning for PHY addresses is left to software.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the configuration word (offset 0) reads 0x0000001D (divisor 29, enable clear), the control word (offset 1) reads 0x00000080, the read-data word (offset 3) reads 0, MDC is low and the MDIO output enable is low.
- R2: The control word sits at offset 1. PHY address is in bits 28:24, register address in bits 20:16, read opcode in bit 15, write opcode in bit 14 and initiate in bit 11. These fields read back as last accepted. A control write without bit 11 set produces no bus activity.
- R3: Control bit 7 reads 0 from the cycle after a transaction is launched until the frame ends, and reads 1 whenever the controller is idle.
- R4: The configuration word sits at offset 0, with the divisor in bits 5:0 and the bus enable in bit 6, and it reads back as written. An initiate issued while the enable is clear produces no bus activity and leaves ready at 1.
- R5: MDC is low whenever the controller is idle. During a frame it has a period of 2*(divisor+1) system clocks.
- R6: Each frame carries 64 MDC cycles. The bits are 32 ones, then 0 1, then the opcode (1 0 for a read, 0 1 for a write), then the PHY address MSB first, then the register address MSB first. A write then drives the turnaround 1 0 followed by the low 16 bits of the write-data word (offset 2), MSB first. MDIO changes only while MDC is low, so it is stable at each MDC rising edge.
- R7: During a read, the MDIO output enable is high for the first 46 bits and low from the turnaround through the last data bit. The 16 bits sampled on the MDC rising edges of the data field, MSB first, appear in bits 15:0 of the read-data word (offset 3) once ready returns to 1.
- R8: A control write while a frame is in progress is ignored. The running frame is unchanged, the control fields keep their values and no second frame follows.
- R9: An initiate with both opcode bits set, or with neither, completes at once. Ready stays 1, MDC does not toggle and the read-data word keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register write word offset |
| bus_wdata | input | 32 | Register write data |
| bus_raddr | input | 2 | Register read word offset |
| bus_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (high = drive) |
| mdio_i | input | 1 | MDIO input value from the pin |

## Verification
The assertions check on every cycle that a launch always raises busy and that busy only rises after a launch. They also check that MDC rests low when idle and that MDC toggles only when the half-period counter expires. Further cycle-level checks cover control writes while busy leaving the fields untouched, and initiates with a bad opcode or with the bus disabled never starting a frame. The bench alone can show that the serial bit pattern is right, that the period matches the divisor, and that read data from a modelled PHY lands in the read-data word. It does this by sweeping all 32 PHY addresses across several divisors and both opcodes.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;
  localparam int DATA_W     = 16;
  localparam int AD_W       = 5;

  localparam logic [1:0] A_CFG   = 2'd0;
  localparam logic [1:0] A_CTRL  = 2'd1;
  localparam logic [1:0] A_WDATA = 2'd2;
  localparam logic [1:0] A_RDATA = 2'd3;

  localparam int B_EN     = 6;
  localparam int B_READY  = 7;
  localparam int B_GO     = 11;
  localparam int B_WR     = 14;
  localparam int B_RD     = 15;
  localparam int B_REG_LO = 16;
  localparam int B_PHY_LO = 24;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_BOTH  = 2'b11
  } mdio_op_e;

  function automatic mdio_op_e op_decode(input logic rd_bit, input logic wr_bit);
    return mdio_op_e'({rd_bit, wr_bit});
  endfunction

  function automatic logic op_valid(input mdio_op_e op);
    return (op == OP_READ) || (op == OP_WRITE);
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(
      input logic is_rd, input logic [AD_W-1:0] phy,
      input logic [AD_W-1:0] regad, input logic [DATA_W-1:0] wd);
    logic [1:0] opc;
    logic [1:0] ta;
    logic [DATA_W-1:0] body;
    opc  = is_rd ? 2'b10 : 2'b01;
    ta   = is_rd ? 2'b11 : 2'b10;
    body = is_rd ? '1 : wd;
    return {{32{1'b1}}, 2'b01, opc, phy, regad, ta, body};
  endfunction

  function automatic logic [CNT_W-1:0] frame_pos(input logic [CNT_W-1:0] idx);
    return CNT_W'(FRAME_BITS - 1) - idx;
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;
  logic             mdc_q;
  logic             half_done;

  assign half_done = run && (cnt == div_q);
  assign rise_tick = half_done && !mdc_q;
  assign fall_tick = half_done && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (start) begin
      div_q <= div_in;
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (run) begin
      if (half_done) begin
        cnt   <= '0;
        mdc_q <= ~mdc_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end
  end

  // R5: MDC only moves when a half period has elapsed
  a_r5_mdc_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_q != $past(mdc_q)) |-> ($past(half_done) || $past(start)));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_rd,
  input  logic [AD_W-1:0]   go_phy,
  input  logic [AD_W-1:0]   go_reg,
  input  logic [DATA_W-1:0] go_wd,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_word,
  output logic              frame_done
);

  logic [FRAME_BITS-1:0] frame_q;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  is_rd;
  logic [DATA_W-1:0]     rx_shift;
  logic                  in_rx_field;
  logic                  released;

  assign frame_done  = busy && fall_tick && (bit_cnt == CNT_W'(FRAME_BITS - 1));
  assign in_rx_field = is_rd && (bit_cnt >= CNT_W'(DATA_IDX));
  assign released    = is_rd && (bit_cnt >= CNT_W'(TA_IDX));

  assign mdio_o  = busy ? frame_q[frame_pos(bit_cnt)] : 1'b1;
  assign mdio_oe = busy && !released;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      frame_q  <= '1;
      bit_cnt  <= '0;
      is_rd    <= 1'b0;
      rx_shift <= '0;
      rd_word  <= '0;
    end else if (go) begin
      busy     <= 1'b1;
      frame_q  <= build_frame(go_rd, go_phy, go_reg, go_wd);
      bit_cnt  <= '0;
      is_rd    <= go_rd;
      rx_shift <= '0;
    end else if (busy) begin
      if (rise_tick && in_rx_field)
        rx_shift <= {rx_shift[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (frame_done) begin
          busy <= 1'b0;
          if (is_rd) rd_word <= rx_shift;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  // R8: a launch can never land on a frame already running
  a_r8_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !go);

  // R7: read data only changes at the end of a read frame
  a_r7_rdata_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word != $past(rd_word)) |-> $past(frame_done));

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W     = 6,
  parameter int DIV_RESET = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [1:0]        bus_raddr,
  output logic [31:0]       bus_rdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_word,
  output logic              go,
  output logic              go_rd,
  output logic [AD_W-1:0]   go_phy,
  output logic [AD_W-1:0]   go_reg,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DIV_W-1:0]  div_q
);

  logic             en_q;
  logic [AD_W-1:0]  phy_q;
  logic [AD_W-1:0]  reg_q;
  mdio_op_e         op_q;
  mdio_op_e         req_op;
  logic             ctrl_wr;
  logic             ctrl_accept;
  logic             go_req;
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata;

  assign ctrl_wr     = bus_wr && (bus_addr == A_CTRL);
  assign ctrl_accept = ctrl_wr && !busy;
  assign req_op      = op_decode(bus_wdata[B_RD], bus_wdata[B_WR]);
  assign go_req      = ctrl_accept && bus_wdata[B_GO];
  assign go          = go_req && en_q && op_valid(req_op);
  assign go_rd       = (req_op == OP_READ);
  assign go_phy      = bus_wdata[B_PHY_LO +: AD_W];
  assign go_reg      = bus_wdata[B_REG_LO +: AD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= DIV_W'(DIV_RESET);
      en_q    <= 1'b0;
      wdata_q <= '0;
      phy_q   <= '0;
      reg_q   <= '0;
      op_q    <= OP_NONE;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CFG: begin
          div_q <= bus_wdata[DIV_W-1:0];
          en_q  <= bus_wdata[B_EN];
        end
        A_WDATA: wdata_q <= bus_wdata[DATA_W-1:0];
        A_CTRL: if (ctrl_accept) begin
          phy_q <= go_phy;
          reg_q <= go_reg;
          op_q  <= req_op;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_raddr)
      A_CFG: begin
        bus_rdata[DIV_W-1:0] = div_q;
        bus_rdata[B_EN]      = en_q;
      end
      A_CTRL: begin
        bus_rdata[B_PHY_LO +: AD_W] = phy_q;
        bus_rdata[B_REG_LO +: AD_W] = reg_q;
        bus_rdata[B_RD]             = op_q[1];
        bus_rdata[B_WR]             = op_q[0];
        bus_rdata[B_READY]          = !busy;
      end
      A_WDATA: bus_rdata[DATA_W-1:0] = wdata_q;
      default: bus_rdata[DATA_W-1:0] = rd_word;
    endcase
  end

  // R8: control fields hold while a frame runs
  a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr) |=> ($stable(phy_q) && $stable(reg_q) && $stable(op_q)));

  // R9: a bad opcode never starts a frame
  a_r9_bad_op_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && !op_valid(req_op)) |=> !busy);

  // R4: a disabled bus never starts a frame
  a_r4_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (go_req && !en_q) |=> !busy);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W     = 6,
  parameter int DIV_RESET = 29
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [1:0]  bus_raddr,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic              go;
  logic              go_rd;
  logic [AD_W-1:0]   go_phy;
  logic [AD_W-1:0]   go_reg;
  logic [DATA_W-1:0] wdata_q;
  logic [DIV_W-1:0]  div_q;
  logic              busy;
  logic [DATA_W-1:0] rd_word;
  logic              rise_tick;
  logic              fall_tick;
  logic              frame_done;

  mdio_reg_bank #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .busy(busy), .rd_word(rd_word), .go(go), .go_rd(go_rd),
    .go_phy(go_phy), .go_reg(go_reg), .wdata_q(wdata_q), .div_q(div_q)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst_n(rst_n), .start(go), .run(busy), .div_in(div_q),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .go_rd(go_rd), .go_phy(go_phy),
    .go_reg(go_reg), .go_wd(wdata_q), .rise_tick(rise_tick),
    .fall_tick(fall_tick), .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rd_word(rd_word), .frame_done(frame_done)
  );

  // R3: ready drops the cycle after a launch
  a_r3_go_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  // R2: busy only ever rises from a launch
  a_r2_busy_from_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));

  // R5: MDC rests low and MDIO is released while idle
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [1:0]  bus_raddr = 2'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rcount = 0;
  int fcount = 0;
  int period_err = 0;
  int last_rise = 0;
  int cur_div = 0;
  logic [15:0] phy_resp = 16'h0;
  logic rec_o [64];
  logic rec_oe [64];

  always #2.5 clk = ~clk;

  mdio_mgmt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d expected <150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // PHY-side monitor: record what the master shows at each MDC rise
  always @(posedge mdc) begin
    #1;
    if (rcount < 64) begin
      rec_o[rcount]  = mdio_o;
      rec_oe[rcount] = mdio_oe;
    end
    if (rcount > 0 && (cyc - last_rise) != 2 * (cur_div + 1)) period_err++;
    last_rise = cyc;
    rcount++;
  end

  // PHY-side responder: present the next bit after each MDC fall
  always @(negedge mdc) begin
    #1;
    fcount++;
    if (fcount >= 48 && fcount <= 63) mdio_i = phy_resp[63 - fcount];
    else mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_raddr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] w;
    for (int k = 0; k < 20000; k++) begin
      bus_read(2'd1, w);
      if (w[7]) break;
    end
  endtask

  function automatic logic [31:0] ctrl_word(input logic rd, input logic wr,
      input logic go, input logic [4:0] phy, input logic [4:0] ra);
    return (32'(phy) << 24) | (32'(ra) << 16) | (32'(rd) << 15) |
           (32'(wr) << 14) | (32'(go) << 11);
  endfunction

  // Expected serial bit i of a frame, derived from the requirement text
  function automatic logic exp_bit(input int i, input logic rd,
      input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
    if (i < 32) return 1'b1;
    if (i == 32) return 1'b0;
    if (i == 33) return 1'b1;
    if (i == 34) return rd;
    if (i == 35) return !rd;
    if (i < 41) return phy[4 - (i - 36)];
    if (i < 46) return ra[4 - (i - 41)];
    if (i == 46) return 1'b1;
    if (i == 47) return 1'b0;
    return wd[15 - (i - 48)];
  endfunction

  task automatic start_txn(input logic rd, input logic [4:0] phy,
      input logic [4:0] ra, input logic [15:0] wd, input logic [15:0] resp,
      input int div);
    logic [31:0] w;
    cur_div = div;
    bus_write(2'd0, 32'(div) | 32'h40);
    bus_write(2'd2, {16'h0, wd});
    phy_resp = resp;
    rcount = 0; fcount = 0; period_err = 0; mdio_i = 1'b1;
    bus_write(2'd1, ctrl_word(rd, !rd, 1'b1, phy, ra));
    bus_read(2'd1, w);
    check(w[7] == 1'b0, "R3", "ready low while busy", w[7], 0);
  endtask

  task automatic finish_txn(input logic rd, input logic [4:0] phy,
      input logic [4:0] ra, input logic [15:0] wd, input logic [15:0] resp);
    logic [31:0] w;
    int mism, oe_mism;
    wait_idle();
    mism = 0; oe_mism = 0;
    for (int i = 0; i < 64; i++) begin
      if (rd && i >= 46) begin
        if (rec_oe[i] !== 1'b0) oe_mism++;
      end else begin
        if (rec_oe[i] !== 1'b1) oe_mism++;
        if (rec_o[i] !== exp_bit(i, rd, phy, ra, wd)) mism++;
      end
    end
    check(rcount == 64, "R6", "MDC cycles per frame", rcount, 64);
    check(mism == 0, "R6", "frame bit mismatches", mism, 0);
    check(period_err == 0, "R5", "MDC period errors", period_err, 0);
    check(oe_mism == 0, rd ? "R7" : "R6", "output enable mismatches", oe_mism, 0);
    check(mdc == 1'b0, "R5", "MDC low when idle", mdc, 0);
    bus_read(2'd1, w);
    check(w == (ctrl_word(rd, !rd, 1'b0, phy, ra) | 32'h80), "R2",
          "control readback", w, ctrl_word(rd, !rd, 1'b0, phy, ra) | 32'h80);
    if (rd) begin
      bus_read(2'd3, w);
      check(w == {16'h0, resp}, "R7", "read data", w, {16'h0, resp});
    end
  endtask

  task automatic expect_quiet(input string req, input logic [31:0] rdata_exp);
    logic [31:0] w;
    bus_read(2'd1, w);
    check(w[7] == 1'b1, req, "ready stays high", w[7], 1);
    repeat (100) @(negedge clk);
    check(rcount == 0, req, "no MDC activity", rcount, 0);
    check(mdio_oe == 1'b0, req, "MDIO released", mdio_oe, 0);
    bus_read(2'd3, w);
    check(w == rdata_exp, req, "read data unchanged", w, rdata_exp);
  endtask

  initial begin
    logic [31:0] w;
    logic [15:0] last_rd;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    bus_read(2'd0, w); check(w == 32'h1D, "R1", "config after reset", w, 32'h1D);
    bus_read(2'd1, w); check(w == 32'h80, "R1", "control after reset", w, 32'h80);
    bus_read(2'd3, w); check(w == 32'h0, "R1", "read data after reset", w, 0);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1", "pins after reset", {mdc, mdio_oe}, 0);

    // R4: configuration readback
    bus_write(2'd0, 32'h45);
    bus_read(2'd0, w); check(w == 32'h45, "R4", "config readback", w, 32'h45);

    // R6 R7 R5: sweep all PHY addresses, both opcodes, four divisors
    last_rd = 16'h0;
    for (int i = 0; i < 32; i++) begin
      logic rd;
      logic [4:0] ra;
      logic [15:0] wd, resp;
      rd   = i[0];
      ra   = 5'((i * 7 + 3) & 31);
      wd   = 16'(i * 16'h1357) ^ 16'hA5C3;
      resp = ~wd;
      start_txn(rd, 5'(i), ra, wd, resp, i % 4);
      finish_txn(rd, 5'(i), ra, wd, resp);
      if (rd) last_rd = resp;
    end

    // R5: reset-default divisor 29, read frame
    start_txn(1'b1, 5'd17, 5'd1, 16'h0, 16'h7949, 29);
    finish_txn(1'b1, 5'd17, 5'd1, 16'h0, 16'h7949);
    last_rd = 16'h7949;

    // R7: a write leaves the read data alone
    start_txn(1'b0, 5'd3, 5'd9, 16'hBEEF, 16'h1111, 1);
    finish_txn(1'b0, 5'd3, 5'd9, 16'hBEEF, 16'h1111);
    bus_read(2'd3, w);
    check(w == {16'h0, last_rd}, "R7", "read data kept after write", w, {16'h0, last_rd});

    // R2: no initiate bit, no frame
    rcount = 0;
    bus_write(2'd1, ctrl_word(1'b1, 1'b0, 1'b0, 5'd4, 5'd5));
    expect_quiet("R2", {16'h0, last_rd});

    // R8: control write while busy is ignored
    start_txn(1'b0, 5'd12, 5'd22, 16'h3C5A, 16'h0, 2);
    repeat (20) @(negedge clk);
    bus_write(2'd1, ctrl_word(1'b1, 1'b0, 1'b1, 5'd30, 5'd7));
    finish_txn(1'b0, 5'd12, 5'd22, 16'h3C5A, 16'h0);
    repeat (400) @(negedge clk);
    check(rcount == 64, "R8", "no second frame", rcount, 64);

    // R9: both opcode bits, then neither
    rcount = 0;
    bus_write(2'd1, ctrl_word(1'b1, 1'b1, 1'b1, 5'd8, 5'd8));
    expect_quiet("R9", {16'h0, last_rd});
    rcount = 0;
    bus_write(2'd1, ctrl_word(1'b0, 1'b0, 1'b1, 5'd8, 5'd8));
    expect_quiet("R9", {16'h0, last_rd});

    // R4: enable clear blocks a valid read
    bus_write(2'd0, 32'h03);
    rcount = 0;
    bus_write(2'd1, ctrl_word(1'b1, 1'b0, 1'b1, 5'd1, 5'd2));
    expect_quiet("R4", {16'h0, last_rd});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule